// File: doc/BRIEF.md
# Serial Port Power-Mode and Interrupt Controller

This block sits next to an asynchronous serial transmitter/receiver. It turns the CPU's wait and stop indications into a clock enable, a freeze control and an abort control for the serial core. A configuration bit selects whether wait mode freezes the core or lets it keep running. Stop mode always freezes the core. A frozen transfer continues from the point where it stopped when the CPU leaves the low-power mode through an interrupt. If the low-power mode is left through reset instead, the block raises a one-cycle abort that returns the core to its reset state.

The controller runs on an always-on clock. Its receive-line edge detector therefore keeps working while the core clock is gated. A polarity bit selects which transition counts as active. An active edge latches a flag and, in stop mode, requests a CPU wake-up.

The block collects eight status sources into one status vector and one level interrupt. Five of them follow the core's status lines directly. The other three (receive edge, single-wire bit error, break) are sticky and are cleared by writing 1 to their bit positions.

Top module: `sci_pwr_irq_ctrl`

## Requirements
- R1: With `wait_dis_i`=0, asserting `wait_i` leaves `clk_en_o`=1 and `freeze_o`=0.
- R2: With `wait_dis_i`=1, asserting `wait_i` gives `clk_en_o`=0 and `freeze_o`=1 after the next clock edge.
- R3: `rx_en_o` and `tx_en_o` equal `rx_en_i` and `tx_en_i` in every mode, whatever the value of `wait_dis_i`.
- R4: Asserting `stop_i` gives `clk_en_o`=0 and `freeze_o`=1 after the next clock edge, whatever the value of `wait_dis_i`. Stop takes priority over wait.
- R5: When the wait or stop inputs drop without `exit_rst_i`, `clk_en_o` returns to 1 after the next edge and `abort_o` stays 0, so the transfer resumes.
- R6: A one-cycle `exit_rst_i` makes `abort_o`=1 for exactly the following cycle. It also returns the block to run mode and clears status bits 5 to 7. This clear overrides any set arriving in the same cycle.
- R7: `rx_i` goes through a 2-flop synchronizer. With `rx_pol_i`=0 a falling edge sets status bit 5, and with `rx_pol_i`=1 a rising edge sets it. The bit is set on the third clock edge after the change, in every mode including stop.
- R8: `wake_o` is 1 exactly while status bit 5 is set and the block is in stop mode.
- R9: `flags_o` bit layout: 0 transmit data empty, 1 transmit complete, 2 receive full, 3 overrun, 4 idle line. These five bits equal `lvl_flags_i[4:0]` combinationally. Bit 5 is the receive edge, bit 6 the bit error (set by `err_set_i`) and bit 7 the break (set by `brk_set_i`).
- R10: A cycle with `clr_we_i`=1 clears each of bits 5 to 7 whose `clr_data_i` bit is 1. A set in the same cycle wins over the clear. Writing bits 0 to 4 has no effect.
- R11: `irq_o` is the OR over all eight bits of `flags_o & irq_en_i`. It is a level, not a pulse.
- R12: After reset, `clk_en_o`=1, `freeze_o`=0, `abort_o`=0, `wake_o`=0 and `flags_o[7:5]`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_i | input | 1 | CPU is in wait mode |
| stop_i | input | 1 | CPU is in stop mode |
| wait_dis_i | input | 1 | Freeze the core during wait mode |
| exit_rst_i | input | 1 | Low-power mode is being left through reset (pulse) |
| rx_en_i | input | 1 | Receiver enable configuration |
| tx_en_i | input | 1 | Transmitter enable configuration |
| rx_pol_i | input | 1 | Active-edge polarity: 0 falling, 1 rising |
| rx_i | input | 1 | Raw receive line |
| lvl_flags_i | input | 5 | Level status from the serial core (bits 0 to 4) |
| err_set_i | input | 1 | Bit-error event pulse |
| brk_set_i | input | 1 | Break-detect event pulse |
| irq_en_i | input | 8 | Per-source interrupt enables |
| clr_we_i | input | 1 | Write strobe for write-one-to-clear |
| clr_data_i | input | 8 | Write-one-to-clear data |
| clk_en_o | output | 1 | Clock enable for the serial core |
| freeze_o | output | 1 | Core transfer is held |
| abort_o | output | 1 | One-cycle core reset after a reset-exit |
| rx_en_o | output | 1 | Receiver enable to the core |
| tx_en_o | output | 1 | Transmitter enable to the core |
| wake_o | output | 1 | Wake request to the CPU |
| flags_o | output | 8 | Combined status vector |
| irq_o | output | 1 | Combined interrupt level |

## Verification
A wrong mode state appears at `clk_en_o` and `freeze_o` one edge after the wait or stop inputs change. It can show up as a core that keeps running during a configured freeze, or as a resume that comes with an unwanted abort. A broken synchronizer or polarity selection shows at status bit 5 on the third edge after a line transition: the bit is early, late, or set on the wrong transition. A wrong sticky-flag priority shows one edge after a write strobe or exit pulse, in `flags_o` and, through the enables, in `irq_o`.

// File: rtl/sci_pwr_pkg.sv
package sci_pwr_pkg;
  localparam int NUM_LVL     = 5;
  localparam int NUM_STK     = 3;
  localparam int NUM_SRC     = NUM_LVL + NUM_STK;
  localparam int SYNC_STAGES = 2;

  // sticky index inside the sticky group; flag bit = NUM_LVL + index
  localparam int STK_EDGE = 0;
  localparam int STK_BERR = 1;
  localparam int STK_BRK  = 2;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_FRZ  = 2'd1,
    MODE_STOP = 2'd2
  } mode_e;
endpackage

// File: rtl/sci_rx_edge_det.sv
module sci_rx_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  input  logic pol_i,
  output logic edge_o
);
  localparam int W = SYNC_STAGES + 1;

  // idle line reset value; last stage holds previous synchronized sample
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[W-2:0], rx_i};
  end

  logic cur, prv;
  assign cur = sh_q[SYNC_STAGES-1];
  assign prv = sh_q[SYNC_STAGES];

  assign edge_o = pol_i ? (cur & ~prv) : (~cur & prv);
endmodule

// File: rtl/sci_pwr_mode.sv
module sci_pwr_mode
  import sci_pwr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wait_i,
  input  logic  stop_i,
  input  logic  wait_dis_i,
  input  logic  exit_rst_i,
  output mode_e mode_o,
  output logic  abort_o
);
  mode_e mode_q, mode_d;
  logic  abort_q;

  always_comb begin
    if (exit_rst_i)                mode_d = MODE_RUN;
    else if (stop_i)               mode_d = MODE_STOP;
    else if (wait_i && wait_dis_i) mode_d = MODE_FRZ;
    else                           mode_d = MODE_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RUN;
      abort_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      abort_q <= exit_rst_i;
    end
  end

  assign mode_o  = mode_q;
  assign abort_o = abort_q;
endmodule

// File: rtl/sci_irq_flags.sv
module sci_irq_flags #(
  parameter int NUM_LVL = 5,
  parameter int NUM_STK = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_LVL-1:0]         lvl_i,
  input  logic [NUM_STK-1:0]         set_i,
  input  logic                       clr_we_i,
  input  logic [NUM_STK-1:0]         clr_i,
  input  logic                       flush_i,
  input  logic [NUM_LVL+NUM_STK-1:0] en_i,
  output logic [NUM_LVL+NUM_STK-1:0] flags_o,
  output logic                       irq_o
);
  logic [NUM_STK-1:0] stk_q;

  for (genvar k = 0; k < NUM_STK; k++) begin : g_stk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  stk_q[k] <= 1'b0;
      else if (flush_i)             stk_q[k] <= 1'b0;
      else if (set_i[k])            stk_q[k] <= 1'b1;
      else if (clr_we_i && clr_i[k]) stk_q[k] <= 1'b0;
    end
  end

  assign flags_o = {stk_q, lvl_i};
  assign irq_o   = |(flags_o & en_i);
endmodule

// File: rtl/sci_pwr_irq_ctrl.sv
module sci_pwr_irq_ctrl
  import sci_pwr_pkg::*;
#(
  parameter int N_LVL  = NUM_LVL,
  parameter int N_STK  = NUM_STK,
  parameter int N_SYNC = SYNC_STAGES,
  localparam int N_SRC = N_LVL + N_STK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wait_i,
  input  logic             stop_i,
  input  logic             wait_dis_i,
  input  logic             exit_rst_i,
  input  logic             rx_en_i,
  input  logic             tx_en_i,
  input  logic             rx_pol_i,
  input  logic             rx_i,
  input  logic [N_LVL-1:0] lvl_flags_i,
  input  logic             err_set_i,
  input  logic             brk_set_i,
  input  logic [N_SRC-1:0] irq_en_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_data_i,
  output logic             clk_en_o,
  output logic             freeze_o,
  output logic             abort_o,
  output logic             rx_en_o,
  output logic             tx_en_o,
  output logic             wake_o,
  output logic [N_SRC-1:0] flags_o,
  output logic             irq_o
);
  mode_e            mode;
  logic             edge_hit;
  logic [N_STK-1:0] stk_set;
  logic             unused_clr;

  sci_rx_edge_det #(.SYNC_STAGES(N_SYNC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .pol_i  (rx_pol_i),
    .edge_o (edge_hit)
  );

  sci_pwr_mode u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wait_i     (wait_i),
    .stop_i     (stop_i),
    .wait_dis_i (wait_dis_i),
    .exit_rst_i (exit_rst_i),
    .mode_o     (mode),
    .abort_o    (abort_o)
  );

  always_comb begin
    stk_set           = '0;
    stk_set[STK_EDGE] = edge_hit;
    stk_set[STK_BERR] = err_set_i;
    stk_set[STK_BRK]  = brk_set_i;
  end

  // level bits are not writable
  assign unused_clr = ^clr_data_i[N_LVL-1:0];

  sci_irq_flags #(.NUM_LVL(N_LVL), .NUM_STK(N_STK)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl_flags_i),
    .set_i    (stk_set),
    .clr_we_i (clr_we_i),
    .clr_i    (clr_data_i[N_SRC-1:N_LVL]),
    .flush_i  (exit_rst_i),
    .en_i     (irq_en_i),
    .flags_o  (flags_o),
    .irq_o    (irq_o)
  );

  assign clk_en_o = (mode == MODE_RUN);
  assign freeze_o = (mode != MODE_RUN);
  assign wake_o   = (mode == MODE_STOP) && flags_o[N_LVL+STK_EDGE];
  assign rx_en_o  = rx_en_i;
  assign tx_en_o  = tx_en_i;
endmodule

// File: rtl/sci_pwr_irq_ctrl_chk.sv
module sci_pwr_irq_ctrl_chk
  import sci_pwr_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wait_i,
  input logic               stop_i,
  input logic               wait_dis_i,
  input logic               exit_rst_i,
  input logic               rx_en_i,
  input logic               tx_en_i,
  input logic               err_set_i,
  input logic               brk_set_i,
  input logic [NUM_SRC-1:0] irq_en_i,
  input logic               clr_we_i,
  input logic [NUM_SRC-1:0] clr_data_i,
  input logic               clk_en_o,
  input logic               freeze_o,
  input logic               abort_o,
  input logic               rx_en_o,
  input logic               tx_en_o,
  input logic               wake_o,
  input logic [NUM_SRC-1:0] flags_o,
  input logic               irq_o
);
  AST_WAIT_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && !wait_dis_i && !stop_i) |=> clk_en_o && !freeze_o); // R1

  AST_WAIT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && wait_dis_i && !exit_rst_i) |=> !clk_en_o && freeze_o); // R2

  AST_EN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_o == rx_en_i) && (tx_en_o == tx_en_i)); // R3

  AST_STOP_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !exit_rst_i) |=> !clk_en_o && freeze_o); // R4

  AST_RESUME_NO_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wait_i && !stop_i && !exit_rst_i) |=> clk_en_o && !abort_o); // R5

  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_rst_i |=> abort_o && clk_en_o && (flags_o[7:5] == 3'b000)); // R6

  AST_WAKE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> freeze_o && flags_o[5]); // R8

  AST_BRK_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_data_i[7] && !brk_set_i) |=> !flags_o[7]); // R10

  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_set_i && !exit_rst_i) |=> flags_o[6]); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i == '0) |-> !irq_o); // R11
endmodule

bind sci_pwr_irq_ctrl sci_pwr_irq_ctrl_chk u_chk (.*);

// File: tb/sci_pwr_irq_ctrl_tb.sv
module sci_pwr_irq_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wait_i = 0, stop_i = 0, wait_dis_i = 0, exit_rst_i = 0;
  logic       rx_en_i = 0, tx_en_i = 0, rx_pol_i = 0, rx_i = 1;
  logic [4:0] lvl_flags_i = '0;
  logic       err_set_i = 0, brk_set_i = 0;
  logic [7:0] irq_en_i = '0;
  logic       clr_we_i = 0;
  logic [7:0] clr_data_i = '0;
  logic       clk_en_o, freeze_o, abort_o, rx_en_o, tx_en_o, wake_o, irq_o;
  logic [7:0] flags_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  sci_pwr_irq_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance n posedges, end on a negedge
  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R12 clk_en", clk_en_o, 1);
    chk("R12 freeze", freeze_o, 0);
    chk("R12 abort", abort_o, 0);
    chk("R12 wake", wake_o, 0);
    chk("R12 sticky", {5'b0, flags_o[7:5]}, 0);
  endtask

  task automatic t_wait_run;
    wait_dis_i = 0; wait_i = 1; rx_en_i = 1; tx_en_i = 0;
    step(1);
    chk("R1 clk_en", clk_en_o, 1);
    chk("R1 freeze", freeze_o, 0);
    wait_i = 0;
    step(1);
  endtask

  task automatic t_wait_freeze;
    wait_dis_i = 1; wait_i = 1;
    chk("R3 rx_en", rx_en_o, 1);
    step(1);
    chk("R2 clk_en", clk_en_o, 0);
    chk("R2 freeze", freeze_o, 1);
    chk("R3 rx_en", rx_en_o, 1);
    chk("R3 tx_en", tx_en_o, 0);
    wait_i = 0;
    step(1);
    chk("R5 clk_en", clk_en_o, 1);
    chk("R5 abort", abort_o, 0);
  endtask

  task automatic t_stop;
    wait_dis_i = 0; wait_i = 1; stop_i = 1;
    step(1);
    chk("R4 clk_en", clk_en_o, 0);
    chk("R4 freeze", freeze_o, 1);
    stop_i = 0; wait_i = 0;
    step(1);
    chk("R5 stop resume", clk_en_o, 1);
    chk("R5 no abort", abort_o, 0);
  endtask

  task automatic t_exit_rst;
    brk_set_i = 1;
    step(1);
    brk_set_i = 0;
    chk("R9 brk bit7", flags_o[7], 1);
    wait_dis_i = 1; wait_i = 1;
    step(1);
    chk("R2 frozen", clk_en_o, 0);
    wait_i = 0; exit_rst_i = 1; err_set_i = 1;
    step(1);
    exit_rst_i = 0; err_set_i = 0;
    chk("R6 abort", abort_o, 1);
    chk("R6 run", clk_en_o, 1);
    chk("R6 flush", {5'b0, flags_o[7:5]}, 0);
    step(1);
    chk("R6 abort one cycle", abort_o, 0);
  endtask

  task automatic t_edge;
    rx_pol_i = 0; rx_i = 0;
    step(2);
    chk("R7 not yet", flags_o[5], 0);
    step(1);
    chk("R7 falling", flags_o[5], 1);
    clr_we_i = 1; clr_data_i = 8'h20;
    step(1);
    clr_we_i = 0; clr_data_i = 0;
    chk("R10 clr edge", flags_o[5], 0);
    rx_pol_i = 1;
    step(3);
    chk("R7 no edge on pol change", flags_o[5], 0);
    rx_i = 1;
    step(3);
    chk("R7 rising", flags_o[5], 1);
    clr_we_i = 1; clr_data_i = 8'h20;
    step(1);
    clr_we_i = 0; clr_data_i = 0;
    rx_i = 0;
    step(4);
    chk("R7 falling ignored pol1", flags_o[5], 0);
    rx_pol_i = 0; rx_i = 1;
    step(4);
  endtask

  task automatic t_wake;
    stop_i = 1;
    step(1);
    chk("R8 no wake", wake_o, 0);
    rx_i = 0;
    step(3);
    chk("R7 edge in stop", flags_o[5], 1);
    chk("R8 wake", wake_o, 1);
    chk("R4 still gated", clk_en_o, 0);
    stop_i = 0;
    step(1);
    chk("R8 wake off", wake_o, 0);
    chk("R8 flag held", flags_o[5], 1);
    clr_we_i = 1; clr_data_i = 8'h20;
    rx_i = 1;
    step(1);
    clr_we_i = 0; clr_data_i = 0;
    step(3);
  endtask

  task automatic t_w1c;
    err_set_i = 1;
    step(1);
    err_set_i = 0;
    chk("R9 err bit6", flags_o[6], 1);
    lvl_flags_i = 5'b10101;
    clr_we_i = 1; clr_data_i = 8'h1F;
    step(1);
    clr_we_i = 0; clr_data_i = 0;
    chk("R10 low write no effect", flags_o, 8'h55);
    clr_we_i = 1; clr_data_i = 8'h40; err_set_i = 1;
    step(1);
    clr_we_i = 0; clr_data_i = 0; err_set_i = 0;
    chk("R10 set wins", flags_o[6], 1);
    clr_we_i = 1; clr_data_i = 8'h40;
    step(1);
    clr_we_i = 0; clr_data_i = 0;
    chk("R10 err cleared", flags_o, 8'h15);
  endtask

  task automatic t_irq;
    lvl_flags_i = 5'b00100;
    irq_en_i = 8'h04;
    #1 chk("R11 rdrf irq", irq_o, 1);
    chk("R9 levels", flags_o, 8'h04);
    irq_en_i = 8'hFB;
    #1 chk("R11 masked", irq_o, 0);
    lvl_flags_i = 5'b01000;
    #1 chk("R11 ovr irq", irq_o, 1);
    lvl_flags_i = 0; irq_en_i = 8'h80;
    brk_set_i = 1;
    step(1);
    brk_set_i = 0;
    chk("R11 brk level", irq_o, 1);
    step(2);
    chk("R11 still level", irq_o, 1);
    clr_we_i = 1; clr_data_i = 8'h80;
    step(1);
    clr_we_i = 0; clr_data_i = 0;
    chk("R11 cleared", irq_o, 0);
    irq_en_i = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_ni = 1;
    step(1);
    t_reset();
    t_wait_run();
    t_wait_freeze();
    t_stop();
    t_exit_rst();
    t_edge();
    t_wake();
    t_w1c();
    t_irq();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule